// File: doc/BRIEF.md
# DVB Reed-Solomon Packet Encoder

This block protects MPEG transport packets for cable transmission. It takes a byte stream of 188-byte packets and produces 204-byte coded packets. The data bytes come out unchanged, one clock after they are accepted. Sixteen parity bytes follow them, and those parity bytes are the remainder of a shortened Reed-Solomon code over GF(256). While the parity bytes are being emitted, the block lowers its input ready, so the upstream source stalls for exactly the time the longer output packet needs.

A bypass mode is provided for systems that do no outer coding. In bypass, every input byte, together with its valid and packet-start flags, reappears at the output exactly two clocks later. No parity is added and the input is never stalled. The mode input is treated as static configuration: it is changed only while the stream is idle and both paths have drained.

Top module: `rs_pkt_encoder`

## Requirements
- R1: During and after reset the output valid is low and input ready is high. No parity is pending after reset.
- R2: In encode mode, a byte accepted at a clock edge appears on the output after that edge, unchanged. The output packet-start flag is high only on the first byte of each packet.
- R3: After the 188th data byte of a packet, 16 parity bytes follow on 16 consecutive cycles, highest-order byte first, with packet-start low. Each coded packet is therefore 204 bytes long.
- R4: The parity is the remainder of x^16·m(x) divided by g(x). Here m(x) is the packet with its first byte as the highest-order coefficient, the field polynomial is x^8+x^4+x^3+x^2+1, and g(x) has the roots alpha^0..alpha^15 with alpha = 0x02. Every coded packet therefore evaluates to zero at those roots, and an all-zero packet has all-zero parity.
- R5: In encode mode, input ready is low for exactly the 16 cycles that follow acceptance of the 188th data byte, and high otherwise.
- R6: The parity registers start from zero for every packet, so a packet's parity does not depend on the packets sent before it.
- R7: A cycle with input valid low changes no state, and in encode mode it gives an output valid of low on the next cycle (outside parity emission).
- R8: A byte accepted with the input packet-start flag high begins a new packet at position 0 and clears the partial parity, even if the previous packet was incomplete.
- R9: In bypass mode, output valid, packet-start and data equal the input values from two clocks earlier, and input ready stays high.
- R10: In bypass mode no parity byte is ever added: the number of output bytes equals the number of input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | 1 = pass-through with two-cycle delay, 0 = encode |
| in_valid_i | input | 1 | Input byte present |
| in_sop_i | input | 1 | Input byte is the first byte of a packet |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block accepts a byte at the next edge |
| out_valid_o | output | 1 | Output byte present |
| out_sop_o | output | 1 | Output byte is the first byte of a coded packet |
| out_data_o | output | 8 | Output byte |

## Verification
The encoder is driven with an all-zero packet, which must give zero parity, and with a ramp-like packet sent back to back. It is also driven with a pseudo-random packet that has idle gaps, which separates gap handling from data handling. A cycle-accurate model checks ready and every output byte on every clock. In addition, each captured codeword is evaluated at the sixteen generator roots, so the parity is checked independently of the model's own division. The same packet is sent once after an unrelated packet and once again later, which shows that parity clears between packets. A truncated packet followed by a new packet-start shows the resynchronisation behaviour. A gapped bypass stream confirms the two-cycle delay and that the byte count is preserved.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;

  localparam int          SYM_W     = 8;
  localparam logic [8:0]  FIELD_POLY = 9'h11D;
  localparam int          MAX_PAR   = 32;

  typedef enum logic {PH_DATA = 1'b0, PH_PARITY = 1'b1} phase_e;

  // GF(256) multiply, shift-and-add with reduction by the field polynomial
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ FIELD_POLY[7:0]) : (sh << 1);
    end
    return acc;
  endfunction

  // Coefficients 0..n-1 of the monic generator prod (x + alpha^i), i = 0..n-1
  function automatic logic [8*MAX_PAR-1:0] gen_poly(input int n);
    logic [7:0] c [MAX_PAR+1];
    logic [7:0] root;
    logic [8*MAX_PAR-1:0] res;
    for (int k = 0; k <= MAX_PAR; k++) c[k] = 8'h00;
    c[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < MAX_PAR; i++) begin
      if (i < n) begin
        for (int j = MAX_PAR; j > 0; j--) c[j] = c[j-1] ^ gf_mul(c[j], root);
        c[0] = gf_mul(c[0], root);
        root = gf_mul(root, 8'h02);
      end
    end
    res = '0;
    for (int k = 0; k < MAX_PAR; k++) res[8*k +: 8] = c[k];
    return res;
  endfunction

endpackage

// File: rtl/rs_parity_lfsr.sv
`timescale 1ns/1ps
module rs_parity_lfsr #(
  parameter int NPAR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic       shift_i,
  input  logic [7:0] data_i,
  output logic [7:0] top_o
);
  import rs_pkg::*;

  localparam logic [8*MAX_PAR-1:0] GCO = gen_poly(NPAR);
  localparam int TOP = NPAR - 1;

  logic [8*NPAR-1:0] par_flat;
  logic [7:0]        fb;
  logic              en;

  assign en    = upd_i | shift_i | clr_i;
  assign fb    = data_i ^ (clr_i ? 8'h00 : par_flat[8*TOP +: 8]);
  assign top_o = par_flat[8*TOP +: 8];

  for (genvar g = 0; g < NPAR; g++) begin : g_stage
    logic [7:0] q;
    logic [7:0] d;
    logic [7:0] prev;

    if (g == 0) begin : g_first
      assign prev = 8'h00;
    end else begin : g_rest
      assign prev = par_flat[8*(g-1) +: 8];
    end

    always_comb begin
      if (upd_i)        d = (clr_i ? 8'h00 : prev) ^ gf_mul(fb, GCO[8*g +: 8]);
      else if (shift_i) d = prev;
      else              d = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 8'h00;
      else if (en) q <= d;
    end

    assign par_flat[8*g +: 8] = q;
  end

  AST_NO_SHIFT_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> !upd_i) else $error("parity shift overlaps data update"); // R3

endmodule

// File: rtl/rs_delay_pipe.sv
`timescale 1ns/1ps
module rs_delay_pipe #(
  parameter int LAT = 2,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic         sop_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic         sop_o,
  output logic [W-1:0] dat_o
);
  logic [LAT:0]       v_flat;
  logic [LAT:0]       s_flat;
  logic [W*(LAT+1)-1:0] d_flat;

  assign v_flat[0]     = vld_i;
  assign s_flat[0]     = sop_i;
  assign d_flat[W-1:0] = dat_i;

  for (genvar g = 1; g <= LAT; g++) begin : g_tap
    logic         v_q;
    logic         s_q;
    logic [W-1:0] d_q;
    logic         ld;

    assign ld = v_flat[g-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        s_q <= 1'b0;
      end else begin
        v_q <= v_flat[g-1];
        s_q <= s_flat[g-1] & v_flat[g-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  d_q <= '0;
      else if (ld) d_q <= d_flat[W*(g-1) +: W];
    end

    assign v_flat[g]         = v_q;
    assign s_flat[g]         = s_q;
    assign d_flat[W*g +: W]  = d_q;
  end

  assign vld_o = v_flat[LAT];
  assign sop_o = s_flat[LAT];
  assign dat_o = d_flat[W*LAT +: W];

endmodule

// File: rtl/rs_frame_ctrl.sv
`timescale 1ns/1ps
module rs_frame_ctrl #(
  parameter int K    = 188,
  parameter int NPAR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bypass_i,
  input  logic       in_valid_i,
  input  logic       in_sop_i,
  input  logic [7:0] in_data_i,
  input  logic [7:0] par_top_i,
  output logic       in_ready_o,
  output logic       clr_o,
  output logic       upd_o,
  output logic       shift_o,
  output logic       enc_valid_o,
  output logic       enc_sop_o,
  output logic [7:0] enc_data_o
);
  import rs_pkg::*;

  localparam int CNT_W = $clog2(K);
  localparam int PID_W = (NPAR > 1) ? $clog2(NPAR) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(K - 1);
  localparam logic [PID_W-1:0] LAST_PID = PID_W'(NPAR - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, pos;
  logic [PID_W-1:0] pidx_q, pidx_d;
  logic             ev_q, ev_d, es_q, es_d;
  logic [7:0]       ed_q, ed_d;
  logic             acc, ed_en;

  assign in_ready_o = bypass_i | (phase_q == PH_DATA);
  assign acc        = in_valid_i & in_ready_o & ~bypass_i;
  assign pos        = in_sop_i ? '0 : cnt_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    pidx_d  = pidx_q;
    ev_d    = 1'b0;
    es_d    = 1'b0;
    ed_d    = ed_q;
    clr_o   = 1'b0;
    upd_o   = 1'b0;
    shift_o = 1'b0;
    case (phase_q)
      PH_DATA: begin
        if (acc) begin
          upd_o = 1'b1;
          clr_o = (pos == '0);
          ev_d  = 1'b1;
          es_d  = (pos == '0);
          ed_d  = in_data_i;
          if (pos == LAST_POS) begin
            phase_d = PH_PARITY;
            cnt_d   = '0;
            pidx_d  = '0;
          end else begin
            cnt_d = pos + 1'b1;
          end
        end
      end
      PH_PARITY: begin
        shift_o = 1'b1;
        ev_d    = 1'b1;
        ed_d    = par_top_i;
        if (pidx_q == LAST_PID) begin
          phase_d = PH_DATA;
          pidx_d  = '0;
        end else begin
          pidx_d = pidx_q + 1'b1;
        end
      end
      default: phase_d = PH_DATA;
    endcase
  end

  assign ed_en = ev_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
      pidx_q  <= '0;
      ev_q    <= 1'b0;
      es_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pidx_q  <= pidx_d;
      ev_q    <= ev_d;
      es_q    <= es_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ed_q <= 8'h00;
    else if (ed_en) ed_q <= ed_d;
  end

  assign enc_valid_o = ev_q;
  assign enc_sop_o   = es_q;
  assign enc_data_o  = ed_q;

  AST_LAST_BYTE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pos == LAST_POS) |=> (bypass_i || !in_ready_o)) else $error("no stall after last data byte"); // R5
  AST_PARITY_NO_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PARITY) |=> (enc_valid_o && !enc_sop_o)) else $error("parity byte flagged as start"); // R3

endmodule

// File: rtl/rs_pkt_encoder.sv
`timescale 1ns/1ps
module rs_pkt_encoder #(
  parameter int K       = 188,
  parameter int NPAR    = 16,
  parameter int BYP_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bypass_i,
  input  logic       in_valid_i,
  input  logic       in_sop_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  output logic       out_valid_o,
  output logic       out_sop_o,
  output logic [7:0] out_data_o
);
  logic       clr, upd, shift;
  logic [7:0] par_top;
  logic       enc_valid, enc_sop;
  logic [7:0] enc_data;
  logic       byp_valid, byp_sop;
  logic [7:0] byp_data;
  logic       byp_in_valid;

  rs_frame_ctrl #(.K(K), .NPAR(NPAR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bypass_i    (bypass_i),
    .in_valid_i  (in_valid_i),
    .in_sop_i    (in_sop_i),
    .in_data_i   (in_data_i),
    .par_top_i   (par_top),
    .in_ready_o  (in_ready_o),
    .clr_o       (clr),
    .upd_o       (upd),
    .shift_o     (shift),
    .enc_valid_o (enc_valid),
    .enc_sop_o   (enc_sop),
    .enc_data_o  (enc_data)
  );

  rs_parity_lfsr #(.NPAR(NPAR)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .upd_i   (upd),
    .shift_i (shift),
    .data_i  (in_data_i),
    .top_o   (par_top)
  );

  assign byp_in_valid = in_valid_i & bypass_i;

  rs_delay_pipe #(.LAT(BYP_LAT), .W(8)) u_byp (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (byp_in_valid),
    .sop_i (in_sop_i),
    .dat_i (in_data_i),
    .vld_o (byp_valid),
    .sop_o (byp_sop),
    .dat_o (byp_data)
  );

  always_comb begin
    if (bypass_i) begin
      out_valid_o = byp_valid;
      out_sop_o   = byp_sop;
      out_data_o  = byp_data;
    end else begin
      out_valid_o = enc_valid;
      out_sop_o   = enc_sop;
      out_data_o  = enc_data;
    end
  end

  // edges since reset, bounds the $past look-back of the checks below
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_SOP_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop_o |-> out_valid_o) else $error("start flag without valid"); // R2
  AST_ENC_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd1 && !bypass_i && $past(!bypass_i) && $past(in_valid_i && in_ready_o))
      |-> (out_valid_o && out_data_o == $past(in_data_i))) else $error("accepted byte not echoed"); // R2
  AST_ENC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd1 && !bypass_i && $past(!bypass_i) && $past(!in_valid_i && in_ready_o))
      |-> !out_valid_o) else $error("output valid after idle cycle"); // R7
  AST_BYP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2 && bypass_i && $past(bypass_i) && $past(bypass_i, 2))
      |-> (out_valid_o == $past(in_valid_i, 2) && (!out_valid_o || out_data_o == $past(in_data_i, 2))))
      else $error("bypass delay mismatch"); // R9

endmodule

// File: tb/sim_rs_pkt_encoder.sv
`timescale 1ns/1ps
module sim_rs_pkt_encoder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bypass;
  logic       in_valid;
  logic       in_sop;
  logic [7:0] in_data;
  logic       in_ready_o;
  logic       out_valid_o;
  logic       out_sop_o;
  logic [7:0] out_data_o;

  rs_pkt_encoder u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bypass_i    (bypass),
    .in_valid_i  (in_valid),
    .in_sop_i    (in_sop),
    .in_data_i   (in_data),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_sop_o   (out_sop_o),
    .out_data_o  (out_data_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  int gexp [0:509];
  int glog [0:255];
  int gpoly [0:16];

  // behavioural model state
  int    m_pos;
  int    m_pkt [0:187];
  int    m_par [$];
  bit    ev, es, er;
  int    ed;
  bit    b1v, b1s;
  int    b1d;
  string mtag = "R1";

  // output capture
  int cap [0:203];
  int cap_n = 0;
  int last_par [0:15];
  int codewords = 0;
  int byp_sent = 0;
  int byp_seen = 0;
  int ready_low = 0;

  function automatic int gm(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return gexp[glog[a] + glog[b]];
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void calc_parity();
    int poly [0:203];
    int c;
    for (int i = 0; i < 204; i++) poly[i] = (i < 188) ? m_pkt[i] : 0;
    for (int i = 0; i < 188; i++) begin
      c = poly[i];
      if (c != 0) for (int j = 1; j <= 16; j++) poly[i+j] = poly[i+j] ^ gm(c, gpoly[16-j]);
    end
    m_par.delete();
    for (int i = 188; i < 204; i++) m_par.push_back(poly[i]);
  endfunction

  // model advances on each clock with the inputs the design sees
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_par.delete(); ev = 0; es = 0; ed = 0; er = 1;
      b1v = 0; b1s = 0; b1d = 0; mtag = "R1";
    end else if (bypass) begin
      ev = b1v; es = b1s; ed = b1d;
      b1v = in_valid; b1s = in_sop & in_valid; b1d = in_data;
      er = 1; mtag = "R9";
    end else begin
      int pos;
      b1v = 0; b1s = 0;
      if (m_par.size() > 0) begin
        ev = 1; es = 0; ed = m_par.pop_front(); mtag = "R3";
      end else if (in_valid) begin
        pos = in_sop ? 0 : m_pos;
        mtag = (in_sop && m_pos != 0) ? "R8" : "R2";
        ev = 1; es = (pos == 0); ed = in_data;
        m_pkt[pos] = in_data;
        if (pos == 187) begin calc_parity(); m_pos = 0; end
        else m_pos = pos + 1;
      end else begin
        ev = 0; es = 0; mtag = "R7";
      end
      er = (m_par.size() == 0);
    end
  end

  // compare and capture away from the active edge
  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      check((out_valid_o === ev) && (!ev || (out_data_o == ed[7:0] && out_sop_o === es)),
            mtag, "out{v,sop,data}", int'({out_valid_o, out_sop_o, out_data_o}), int'({ev, es, ed[7:0]}));
      check(in_ready_o === er, bypass ? "R9" : "R5", "in_ready", int'(in_ready_o), int'(er));
      if (!bypass && !in_ready_o) ready_low++;
      if (bypass && out_valid_o) byp_seen++;
      if (!bypass && out_valid_o) begin
        if (out_sop_o) cap_n = 0;
        if (cap_n < 204) begin
          cap[cap_n] = out_data_o;
          cap_n++;
          if (cap_n == 204) begin
            for (int j = 0; j < 16; j++) begin
              int s = 0;
              for (int k = 0; k < 204; k++) s = gm(s, gexp[j]) ^ cap[k];
              check(s == 0, "R4", "syndrome", s, 0);
            end
            for (int k = 0; k < 16; k++) last_par[k] = cap[188+k];
            codewords++;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog all-requirements actual=%0d expected=<60000 cycles", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0;
    end
  endtask

  task automatic put(input int d, input bit s, input int gap);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1; in_data = d[7:0]; in_sop = s;
      acc = in_ready_o;
    end
    if (bypass) byp_sent++;
    if (gap > 0) idle(gap);
  endtask

  task automatic send_pkt(input int seed, input int nbytes, input bit gaps);
    for (int i = 0; i < nbytes; i++) begin
      int d = (seed == 0) ? 0 : ((seed * 29 + i * i * 3 + i * 11) & 255);
      int g = (gaps && ((i * 7 + seed) % 3 == 0)) ? (i % 4) : 0;
      put(d, i == 0, g);
    end
  endtask

  initial begin
    int x;
    int pa [0:15];
    int cw0, rl0;
    bit same;
    x = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = x; gexp[i+255] = x; glog[x] = i;
      x = x << 1;
      if (x & 256) x = x ^ 'h11D;
    end
    for (int j = 0; j <= 16; j++) gpoly[j] = 0;
    gpoly[0] = 1;
    for (int r = 0; r < 16; r++) begin
      for (int j = 16; j > 0; j--) gpoly[j] = gpoly[j-1] ^ gm(gpoly[j], gexp[r]);
      gpoly[0] = gm(gpoly[0], gexp[r]);
    end

    rst_n = 0; bypass = 0; in_valid = 0; in_sop = 0; in_data = 0;
    repeat (3) @(negedge clk);
    check(out_valid_o === 1'b0, "R1", "valid in reset", int'(out_valid_o), 0);
    rst_n = 1; started = 1;
    @(negedge clk);
    check(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R1", "valid/ready after reset",
          int'({out_valid_o, in_ready_o}), 1);

    // all-zero packet: zero parity (R4), length and order (R3), stall count (R5)
    rl0 = ready_low;
    send_pkt(0, 188, 0); idle(24);
    same = 1;
    for (int k = 0; k < 16; k++) if (last_par[k] != 0) same = 0;
    check(same && codewords == 1, "R4", "zero packet parity", codewords, 1);
    check(ready_low - rl0 == 16, "R5", "ready low cycles", ready_low - rl0, 16);
    check(cap_n == 204, "R3", "coded length", cap_n, 204);

    // contiguous pseudo-random packet (R2, R4)
    send_pkt(5, 188, 0); idle(24);
    check(codewords == 2, "R2", "codeword count", codewords, 2);

    // gapped packet A (R7), then unrelated packet and A again (R6)
    send_pkt(9, 188, 1); idle(24);
    for (int k = 0; k < 16; k++) pa[k] = last_par[k];
    send_pkt(77, 188, 1);
    send_pkt(9, 188, 0); idle(24);
    same = 1;
    for (int k = 0; k < 16; k++) if (last_par[k] != pa[k]) same = 0;
    check(same, "R6", "repeat packet parity", last_par[0], pa[0]);
    check(codewords == 5, "R7", "codewords after gaps", codewords, 5);

    // truncated packet, then a fresh packet-start (R8)
    cw0 = codewords;
    send_pkt(33, 60, 0);
    send_pkt(41, 188, 0); idle(24);
    check(codewords == cw0 + 1, "R8", "resync codeword", codewords, cw0 + 1);

    // bypass stream (R9, R10)
    bypass = 1; idle(4);
    for (int i = 0; i < 300; i++) put((i * 13 + 7) & 255, (i % 188) == 0, (i % 5 == 0) ? 1 : 0);
    idle(6);
    check(byp_seen == byp_sent && byp_sent == 300, "R10", "bypass byte count", byp_seen, byp_sent);
    check(in_ready_o === 1'b1 && out_valid_o === 1'b0, "R9", "bypass drained", int'({in_ready_o, out_valid_o}), 2);

    // encode resumes after bypass (R3)
    bypass = 0; idle(4);
    cw0 = codewords;
    send_pkt(12, 188, 0); idle(24);
    check(codewords == cw0 + 1, "R3", "encode after bypass", codewords, cw0 + 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule